// File: doc/BRIEF.md
# Delayed-Write Cartridge RAM Controller

This block serves cartridge RAM on a processor bus that carries only address lines and read data, with no write strobe. The processor still gets write access by reading. A read from the trigger page stores the low address byte in a data latch and arms a write. The block then watches the address bus. On the fifth bus cycle whose address differs from the previous one, it turns that cycle into a write: the latched byte goes into RAM at the address present in that cycle, and the same byte is driven on the data bus.

The cartridge window is the upper half of a 13-bit address space, where bit 12 is set. The trigger page is cartridge offsets $000 to $0FF. RAM consists of several equal banks placed back to back from a base offset. The bank count, the bank size, the base offset and the number of changes that release a write are all parameters. A write-enable bit, set through a one-cycle configuration strobe, gates whether triggers are accepted. While it is clear, the RAM can only be read.

Top module: `dwr_cart_ram`

## Requirements
- R1: A bus cycle (bus_valid=1) whose address has bit 12 set and offset bits [11:8] equal to zero is a trigger when the write-enable bit is set and no write is armed. It stores bus_addr[7:0] in the latch, arms a write, and leaves data_oe low for that cycle.
- R2: While a write is armed, a valid cycle counts as a change only when its address differs from the address of the previous valid cycle. Repeated identical addresses do not count, and cycles with bus_valid low do not count.
- R3: The valid cycle that makes the fifth change commits the write. If its address lies in RAM, the latched byte is stored there and reads back from that address later.
- R4: In the clock cycle after a commit whose address has bit 12 set, data_oe is 1 and data_out carries the latched byte, not the RAM contents.
- R5: While a write is armed, a further trigger-page access does not reload the latch. It only counts as an ordinary address change.
- R6: A cfg_we pulse loads cfg_wen into the write-enable bit. While the bit is 0, trigger-page accesses arm nothing and RAM contents do not change.
- R7: A commit whose address lies outside RAM writes nothing and ends the armed state. If that address has bit 12 clear, data_oe stays 0.
- R8: A valid cycle that is not a commit and hits RAM gives data_oe=1 and the stored byte on data_out in the next clock cycle. Every other cycle gives data_oe=0.
- R9: Reset clears the armed state, the change counter, the write-enable bit and data_oe. RAM contents are kept.
- R10: With the default parameters, RAM is three 256-byte banks at offsets $100-$1FF, $200-$2FF and $300-$3FF, with bit 12 set. Each address holds its own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | One bus cycle is present this clock |
| bus_addr | input | 13 | Bus address; bit 12 selects the cartridge window |
| cfg_we | input | 1 | Load strobe for the write-enable bit |
| cfg_wen | input | 1 | Value loaded into the write-enable bit |
| data_out | output | 8 | Data driven on the bus for the previous bus cycle |
| data_oe | output | 1 | data_out is driven |

## Verification
A wrong change count or a badly compared previous address shows up one clock after the intended commit. At that point data_oe and data_out show either a RAM read or silence instead of the latched byte, or the latched byte appears one change early. A latch corrupted while a write is armed shows in the byte driven at the commit and again on any later read of that address. Faulty write-enable or reset state shows only on readback, as a RAM byte that changed when it should have stayed put. The bench therefore follows every armed write with reads of the affected addresses.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
   // source of the data driven for the previous bus cycle
   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_RAM   = 2'd1,
      SRC_LATCH = 2'd2
   } out_src_e;
endpackage

// File: rtl/dwr_decode.sv
module dwr_decode #(
   parameter int ADDR_W    = 13,
   parameter int BANK_AW   = 8,
   parameter int NUM_BANKS = 3,
   parameter int RAM_BASE  = 256
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic                 is_cart,
   output logic                 is_trig,
   output logic [NUM_BANKS-1:0] bank_hit,
   output logic                 ram_hit,
   output logic [BANK_AW-1:0]   word_idx
);
   localparam int OFF_W      = ADDR_W - 1;
   localparam int BANK_BYTES = 1 << BANK_AW;

   logic [OFF_W-1:0] off;

   assign is_cart  = addr[ADDR_W-1];
   assign off      = addr[OFF_W-1:0];
   assign is_trig  = is_cart && (off[OFF_W-1:8] == '0);
   assign word_idx = off[BANK_AW-1:0];

   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_hit
      localparam int LO = RAM_BASE + k * BANK_BYTES;
      localparam int HI = LO + BANK_BYTES;
      assign bank_hit[k] = is_cart && (int'(off) >= LO) && (int'(off) < HI);
   end

   assign ram_hit = |bank_hit;
endmodule

// File: rtl/dwr_seq.sv
module dwr_seq #(
   parameter int ADDR_W  = 13,
   parameter int DATA_W  = 8,
   parameter int CHANGES = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_trig,
   input  logic              cfg_we,
   input  logic              cfg_wen,
   output logic              pending,
   output logic              commit,
   output logic [DATA_W-1:0] latch
);
   localparam int CNT_W = $clog2(CHANGES + 1);

   logic [ADDR_W-1:0] prev_addr;
   logic [CNT_W-1:0]  cnt;
   logic              wen;
   logic              changed;

   assign changed = valid && (addr != prev_addr);
   assign commit  = pending && changed && (cnt == CNT_W'(CHANGES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending   <= 1'b0;
         cnt       <= '0;
         wen       <= 1'b0;
         prev_addr <= '0;
         latch     <= '0;
      end else begin
         if (cfg_we) wen <= cfg_wen;
         if (valid) begin
            prev_addr <= addr;
            if (pending) begin
               if (commit) begin
                  pending <= 1'b0;
                  cnt     <= '0;
               end else if (changed) begin
                  cnt <= cnt + 1'b1;
               end
            end else if (wen && is_trig) begin
               pending <= 1'b1;
               cnt     <= '0;
               latch   <= addr[DATA_W-1:0];
            end
         end
      end
   end

   // counter never reaches the release count while armed
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> (cnt < CNT_W'(CHANGES)));
   // counter rests at zero when nothing is armed
   p_idle_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pending |-> (cnt == '0));
   // latch frozen while armed, so a second trigger cannot reload it
   p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pending |=> $stable(latch));
   // with the enable bit clear nothing becomes armed
   p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wen && !pending) |=> !pending);
endmodule

// File: rtl/dwr_bank.sv
module dwr_bank #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          re,
   input  logic [AW-1:0] idx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
      if (re) rdata <= mem[idx];
   end

   // a cycle is either the commit write or a read, never both
   p_rw_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && re));
endmodule

// File: rtl/dwr_cart_ram.sv
module dwr_cart_ram #(
   parameter int ADDR_W    = 13,
   parameter int DATA_W    = 8,
   parameter int BANK_AW   = 8,
   parameter int NUM_BANKS = 3,
   parameter int RAM_BASE  = 256,
   parameter int CHANGES   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              cfg_we,
   input  logic              cfg_wen,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe
);
   import dwr_pkg::*;

   localparam int BANK_BYTES = 1 << BANK_AW;
   localparam int RAM_END    = RAM_BASE + NUM_BANKS * BANK_BYTES;

   initial begin
      assert (DATA_W == 8) else $error("latch carries one address byte");
      assert (ADDR_W >= 10) else $error("address too narrow");
      assert (CHANGES >= 1) else $error("release count must be positive");
      assert (RAM_BASE >= 256) else $error("RAM overlaps trigger page");
      assert (RAM_BASE % BANK_BYTES == 0) else $error("RAM base misaligned");
      assert (RAM_END <= (1 << (ADDR_W - 1))) else $error("RAM exceeds window");
   end

   logic                 is_cart, is_trig, ram_hit;
   logic [NUM_BANKS-1:0] bank_hit;
   logic [BANK_AW-1:0]   word_idx;
   logic                 pending, commit;
   logic [DATA_W-1:0]    latch;

   dwr_decode #(
      .ADDR_W(ADDR_W), .BANK_AW(BANK_AW),
      .NUM_BANKS(NUM_BANKS), .RAM_BASE(RAM_BASE)
   ) u_dec (
      .addr(bus_addr), .is_cart(is_cart), .is_trig(is_trig),
      .bank_hit(bank_hit), .ram_hit(ram_hit), .word_idx(word_idx)
   );

   dwr_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHANGES(CHANGES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .valid(bus_valid), .addr(bus_addr),
      .is_trig(is_trig), .cfg_we(cfg_we), .cfg_wen(cfg_wen),
      .pending(pending), .commit(commit), .latch(latch)
   );

   logic [DATA_W-1:0] bank_rd [NUM_BANKS];

   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
      dwr_bank #(.AW(BANK_AW), .DW(DATA_W)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .we(commit && bank_hit[k]),
         .re(bus_valid && bank_hit[k] && !commit),
         .idx(word_idx), .wdata(latch), .rdata(bank_rd[k])
      );
   end

   out_src_e             src_q;
   logic [NUM_BANKS-1:0] sel_q;
   logic [DATA_W-1:0]    drv_q;
   out_src_e             src_d;

   always_comb begin
      src_d = SRC_NONE;
      if (bus_valid) begin
         if (commit) src_d = is_cart ? SRC_LATCH : SRC_NONE;
         else if (ram_hit) src_d = SRC_RAM;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= SRC_NONE;
         sel_q <= '0;
         drv_q <= '0;
      end else begin
         src_q <= src_d;
         sel_q <= bank_hit;
         if (commit) drv_q <= latch;
      end
   end

   logic [DATA_W-1:0] ram_mux;
   always_comb begin
      ram_mux = '0;
      for (int k = 0; k < NUM_BANKS; k++)
         if (sel_q[k]) ram_mux = ram_mux | bank_rd[k];
   end

   assign data_oe  = (src_q != SRC_NONE);
   assign data_out = (src_q == SRC_LATCH) ? drv_q : ram_mux;

   // commit in the cartridge window drives the latched byte next cycle
   p_commit_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && is_cart) |=> (data_oe && data_out == $past(latch)));
   // the bus is driven only for a preceding valid cycle
   p_oe_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> $past(bus_valid));
   // at most one bank answers a read
   p_one_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_q));
   // a commit outside the window leaves the bus undriven
   p_far_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !is_cart) |=> !data_oe);
endmodule

// File: tb/sim_dwr_cart_ram.sv
module sim_dwr_cart_ram;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic [12:0] bus_addr = '0;
   logic        cfg_we = 1'b0;
   logic        cfg_wen = 1'b0;
   logic [7:0]  data_out;
   logic        data_oe;

   always #5 clk = ~clk;

   dwr_cart_ram u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
      .cfg_we(cfg_we), .cfg_wen(cfg_wen), .data_out(data_out), .data_oe(data_oe)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference state
   bit          m_pend, m_wen;
   int          m_cnt;
   logic [7:0]  m_latch;
   logic [12:0] m_prev;
   logic [7:0]  ref_mem [768];
   bit          known [768];

   function automatic bit ram_at(input logic [12:0] a);
      return a[12] && (a[11:0] >= 12'h100) && (a[11:0] < 12'h400);
   endfunction

   function automatic bit trig_at(input logic [12:0] a);
      return a[12] && (a[11:8] == 4'h0);
   endfunction

   task automatic check(input string req, input bit eo, input bit cd, input logic [7:0] ed);
      checks++;
      if (data_oe !== eo || (cd && data_out !== ed)) begin
         fails++;
         $display("FAIL %s: got oe=%0b data=%02h expected oe=%0b data=%02h",
                  req, data_oe, data_out, eo, ed);
      end
   endtask

   task automatic cyc(input bit v, input logic [12:0] a, input string req);
      bit eo = 1'b0, cd = 1'b0, cmt = 1'b0;
      logic [7:0] ed = '0;
      int ix;
      bus_valid = v; bus_addr = a; cfg_we = 1'b0;
      if (v) begin
         if (m_pend) begin
            if (a != m_prev) begin
               m_cnt++;
               if (m_cnt == 5) begin cmt = 1'b1; m_pend = 1'b0; m_cnt = 0; end
            end
         end else if (m_wen && trig_at(a)) begin
            m_pend = 1'b1; m_cnt = 0; m_latch = a[7:0];
         end
         m_prev = a;
         ix = int'(a[11:0]) - 256;
         if (cmt) begin
            eo = a[12]; cd = eo; ed = m_latch;
            if (ram_at(a)) begin ref_mem[ix] = m_latch; known[ix] = 1'b1; end
         end else if (ram_at(a)) begin
            eo = 1'b1; cd = known[ix]; ed = ref_mem[ix];
         end
      end
      @(posedge clk); #2;
      check(req, eo, cd, ed);
      bus_valid = 1'b0;
   endtask

   task automatic set_wen(input bit val);
      cfg_we = 1'b1; cfg_wen = val; bus_valid = 1'b0;
      @(posedge clk); #2;
      cfg_we = 1'b0; m_wen = val;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; bus_valid = 1'b0; cfg_we = 1'b0;
      repeat (2) @(posedge clk);
      #2; rst_n = 1'b1;
      m_pend = 1'b0; m_cnt = 0; m_wen = 1'b0; m_prev = '0;
   endtask

   // armed write: trigger, four fetches, then the target
   task automatic put(input logic [7:0] val, input logic [12:0] tgt, input string req);
      cyc(1, 13'h1000 | 13'(val), "R1");
      cyc(1, 13'h1F03, req);
      cyc(1, 13'h1F04, req);
      cyc(1, 13'h1F05, req);
      cyc(1, 13'h1F06, req);
      cyc(1, tgt, req);
   endtask

   function automatic logic [12:0] rand_addr();
      int r = int'($urandom_range(0, 9));
      case (r)
         0, 1:    return 13'h1000 | 13'($urandom_range(0, 255));
         2, 3, 4: return 13'h1100 + 13'($urandom_range(0, 767));
         5:       return 13'h1400 + 13'($urandom_range(0, 3000));
         6:       return 13'h0080 + 13'($urandom_range(0, 127));
         default: return m_prev;
      endcase
   endfunction

   initial begin
      for (int i = 0; i < 768; i++) begin known[i] = 1'b0; ref_mem[i] = '0; end
      void'($urandom(32'd2718));
      do_reset();
      check("R9 reset oe", 1'b0, 1'b0, 8'h00);

      // enable off after reset: triggers do nothing (R9, R6)
      cyc(1, 13'h1021, "R9");
      cyc(1, 13'h1021, "R9");
      check("R9 no arm", 1'b0, 1'b0, 8'h00);

      set_wen(1'b1);
      // example sequence with absolute fetches, lands in bank 1
      put(8'hA5, 13'h1234, "R3");
      cyc(1, 13'h1234, "R3 readback");
      // indirect-style fetches through zero page count too
      cyc(1, 13'h105A, "R1");
      cyc(1, 13'h1103, "R2");
      cyc(1, 13'h1104, "R2");
      cyc(1, 13'h0080, "R2");
      cyc(1, 13'h0081, "R2");
      cyc(1, 13'h1345, "R4");
      cyc(1, 13'h1345, "R8 readback");

      // repeats and idle cycles do not count
      cyc(1, 13'h103C, "R1");
      cyc(1, 13'h1500, "R2");
      cyc(1, 13'h1500, "R2 repeat");
      cyc(0, 13'h1600, "R2 idle");
      cyc(1, 13'h1501, "R2");
      cyc(1, 13'h1502, "R2");
      cyc(1, 13'h1503, "R2");
      cyc(1, 13'h1150, "R3 fifth");
      cyc(1, 13'h1150, "R3 readback");

      // second trigger while armed is ignored
      cyc(1, 13'h1011, "R1");
      cyc(1, 13'h1077, "R5");
      cyc(1, 13'h1501, "R5");
      cyc(1, 13'h1502, "R5");
      cyc(1, 13'h1503, "R5");
      cyc(1, 13'h1151, "R5 commit");
      cyc(1, 13'h1151, "R5 readback");

      // bank boundaries hold separate bytes
      put(8'h01, 13'h1100, "R10");
      put(8'h02, 13'h11FF, "R10");
      put(8'h03, 13'h1200, "R10");
      put(8'h04, 13'h13FF, "R10");
      cyc(1, 13'h1100, "R10");
      cyc(1, 13'h11FF, "R10");
      cyc(1, 13'h1200, "R10");
      cyc(1, 13'h13FF, "R10");

      // commit outside RAM
      put(8'h66, 13'h0090, "R7 outside bus");
      put(8'h67, 13'h1055, "R7 trigger page");
      put(8'h68, 13'h1800, "R7 cart beyond RAM");
      put(8'h69, 13'h1101, "R7 next write ok");
      cyc(1, 13'h1101, "R7 readback");

      // enable cleared: read-only
      set_wen(1'b0);
      put(8'hEE, 13'h1234, "R6");
      cyc(1, 13'h1234, "R6 unchanged");
      set_wen(1'b1);

      // reset keeps RAM, clears enable
      do_reset();
      put(8'hDD, 13'h1345, "R9");
      cyc(1, 13'h1345, "R9 unchanged");
      set_wen(1'b1);

      // random traffic
      for (int n = 0; n < 6000; n++) begin
         if ($urandom_range(0, 199) == 0) set_wen($urandom_range(0, 3) != 0);
         cyc($urandom_range(0, 99) < 85, rand_addr(), "R2 random");
      end
      for (int i = 0; i < 768; i++)
         if (known[i]) cyc(1, 13'h1100 + 13'(i), "R8 sweep");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #5_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule